// File: doc/BRIEF.md
# Protected Clock Prescaler Controller

This block holds the divider setting for a system clock. The setting sits in one 8-bit register behind a plain write port. The divider cannot be changed by a single stray write. Software first writes a lone enable bit, which opens a window four cycles long. Within that window a second write may load a new divide select. The window closes by itself, and writing the enable pattern again cannot lengthen it.

The applied setting drives a divide counter. That counter produces a one-cycle clock-enable pulse once every 2^N source cycles. All synchronous consumers of the system clock gate on this pulse, so they run slower by the same factor. A newly accepted select waits inside the block until the counter reaches its terminal count. Because of this, a change of divider never produces a shortened period.

Top module: `clk_prescale_ctrl`

## Requirements
- R1: Read data is laid out as follows: bit 7 is the change-enable flag, bits 6..4 always read 0, and bits 3..0 hold the stored divide select.
- R2: The flag is set only by a write whose value is exactly 0x80. A write with bit 7 set and any other bit set leaves the flag unchanged.
- R3: Once set, the flag reads 1 for exactly four cycles and then clears by itself. A select write is therefore accepted at any of the four clock edges that follow the unlock edge.
- R4: While the flag is set, a write with bit 7 = 0 is a select write. It clears the flag at that same edge.
- R5: Writing 0x80 again while the flag is set neither restarts the four-cycle timeout nor clears the flag.
- R6: A write with bit 7 = 0 while the flag is clear leaves the stored select unchanged.
- R7: A select write carrying a value from 9 to 15 is reserved. It leaves the stored select unchanged, but it still clears the flag.
- R8: An applied select N (from 0 to 8) makes the clock-enable output pulse high for one cycle out of every 2^N cycles. With N = 0 the output is high on every cycle.
- R9: A new select is applied only on the cycle of a clock-enable pulse, which is the terminal count. The applied-divider output changes only on such a cycle, so no enable period is shorter than the old divider or the new one.
- R10: After synchronous reset, the register reads 0x00, the applied divider is 0, the clock enable is low and the divide counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| div_log2 | output | 4 | Applied divide select N (factor 2^N) |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
The bench targets the edges of the unlock window. A select write on the fourth edge after the unlock must land, and one on the fifth must not. A design with an off-by-one timer would accept too late or reject too early. Repeated unlock writes inside the window are checked for not extending it, and writes such as 0x81 are checked for not opening it. A loose match on bit 7 would arm the flag on those writes. The reserved select values are also exercised: a design that stored them would later apply a divider outside the legal set. Divider changes issued in mid-period are checked cycle by cycle against a model, which shows whether the new factor cuts short the period already running.

// File: rtl/clk_prescale_pkg.sv
package clk_prescale_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 4;
  localparam int FLAG_BIT = 7;
  localparam logic [REG_W-1:0] UNLOCK_CODE = 8'h80;
endpackage

// File: rtl/cpc_unlock.sv
module cpc_unlock #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic unlock_req,
  input  logic sel_req,
  output logic flag,
  output logic sel_take
);
  localparam int TW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [TW-1:0] T_START = TW'(WINDOW - 1);

  logic [TW-1:0] timer_q;

  // a select write is honoured only while the window is open
  assign sel_take = sel_req && flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      timer_q <= '0;
    end else if (sel_take) begin
      flag    <= 1'b0;
      timer_q <= '0;
    end else if (flag) begin
      if (timer_q == '0) flag <= 1'b0;
      else               timer_q <= timer_q - 1'b1;
    end else if (unlock_req) begin
      flag    <= 1'b1;
      timer_q <= T_START;
    end
  end
endmodule

// File: rtl/cpc_sel_reg.sv
module cpc_sel_reg #(
  parameter int SEL_W    = 4,
  parameter int MAX_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] din,
  output logic [SEL_W-1:0] sel_q
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_LOG2);

  logic legal;
  assign legal = (din <= SEL_MAX);

  always_ff @(posedge clk) begin
    if (rst)                sel_q <= '0;
    else if (load && legal) sel_q <= din;
  end
endmodule

// File: rtl/cpc_divider.sv
module cpc_divider #(
  parameter int SEL_W    = 4,
  parameter int MAX_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_pending,
  output logic [SEL_W-1:0] applied,
  output logic             tick
);
  localparam int CW = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          at_end;

  // counter limit is 2^applied - 1: bit i is set when applied exceeds i
  for (genvar i = 0; i < CW; i++) begin : g_limit
    assign limit[i] = (applied > SEL_W'(i));
  end

  assign at_end = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      applied <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= at_end;
      if (at_end) begin
        cnt_q   <= '0;
        applied <= sel_pending;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_prescale_ctrl.sv
module clk_prescale_ctrl
  import clk_prescale_pkg::*;
#(
  parameter int WINDOW   = 4,
  parameter int MAX_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [SEL_W-1:0] div_log2,
  output logic             clk_en
);
  logic             flag;
  logic             sel_take;
  logic             unlock_req;
  logic             sel_req;
  logic [SEL_W-1:0] sel_q;

  assign unlock_req = wr_en && (wr_data == UNLOCK_CODE);
  assign sel_req    = wr_en && !wr_data[FLAG_BIT];

  cpc_unlock #(.WINDOW(WINDOW)) u_unlock (
    .clk(clk), .rst(rst), .unlock_req(unlock_req), .sel_req(sel_req),
    .flag(flag), .sel_take(sel_take)
  );

  cpc_sel_reg #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_sel (
    .clk(clk), .rst(rst), .load(sel_take), .din(wr_data[SEL_W-1:0]),
    .sel_q(sel_q)
  );

  cpc_divider #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_div (
    .clk(clk), .rst(rst), .sel_pending(sel_q), .applied(div_log2),
    .tick(clk_en)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[FLAG_BIT] = flag;
    rd_data[SEL_W-1:0] = sel_q;
  end
endmodule

// File: rtl/clk_prescale_ctrl_chk.sv
module clk_prescale_ctrl_chk #(
  parameter int WINDOW   = 4,
  parameter int MAX_LOG2 = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [3:0] div_log2,
  input logic       clk_en
);
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)             run_len <= '0;
    else if (rd_data[7]) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[6:4] == 3'b000);

  a_r2_set_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[7]) |-> $past(wr_en && wr_data == 8'h80));

  a_r3_window_bound: assert property (@(posedge clk) disable iff (rst)
    run_len <= 8'(WINDOW));

  a_r4_sel_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[7] && rd_data[7]) |=> !rd_data[7]);

  a_r6_sel_guarded: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data[3:0]) |-> $past(wr_en && rd_data[7]));

  a_r8_legal_applied: assert property (@(posedge clk) disable iff (rst)
    div_log2 <= 4'(MAX_LOG2));

  a_r9_apply_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_log2) |-> clk_en);
endmodule

bind clk_prescale_ctrl clk_prescale_ctrl_chk #(.WINDOW(WINDOW), .MAX_LOG2(MAX_LOG2)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .div_log2(div_log2), .clk_en(clk_en)
);

// File: tb/clk_prescale_ctrl_tb.sv
module clk_prescale_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] div_log2;
  logic       clk_en;

  int n_checks = 0;
  int n_errors = 0;
  string tag = "R10";

  // reference state
  logic       m_flag = 1'b0;
  int         m_tmr = 0;
  logic [3:0] m_sel = 4'd0;
  logic [3:0] m_app = 4'd0;
  int         m_cnt = 0;
  logic       m_en = 1'b0;

  always #2 clk = ~clk;

  clk_prescale_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .div_log2(div_log2), .clk_en(clk_en)
  );

  function automatic logic [7:0] exp_rd();
    return {m_flag, 3'b000, m_sel};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update from the requirements, one step per rising edge
  always @(posedge clk) begin
    logic tc;
    logic [3:0] old_sel;
    tc = (m_cnt == (1 << m_app) - 1);
    old_sel = m_sel;
    if (rst) begin
      m_flag = 0; m_tmr = 0; m_sel = 0; m_app = 0; m_cnt = 0; m_en = 0;
    end else begin
      if (wr_en && !wr_data[7] && m_flag) begin
        m_flag = 0;
        if (wr_data[3:0] <= 4'd8) m_sel = wr_data[3:0];
      end else if (m_flag) begin
        if (m_tmr == 0) m_flag = 0; else m_tmr--;
      end else if (wr_en && wr_data == 8'h80) begin
        m_flag = 1; m_tmr = 3;
      end
      m_en = tc;
      if (tc) begin m_cnt = 0; m_app = old_sel; end
      else m_cnt++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    check({tag, " R1 rd_data"}, rd_data, exp_rd());
    check({tag, " R8 clk_en"}, clk_en, m_en);
    check({tag, " R9 div_log2"}, div_log2, m_app);
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // directed: unlock then select after 'gap' idle cycles
  task automatic unlock_sel(input logic [7:0] d, input int gap);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h80;
    @(negedge clk); wr_en = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    tag = "R10";
    idle(3);
    check("R10 reset rd_data", rd_data, 0);
    check("R10 reset clk_en", clk_en, 0);
    @(negedge clk); rst = 1'b0;
    idle(4);

    tag = "R8"; unlock_sel(8'h03, 0); idle(40);
    tag = "R3"; unlock_sel(8'h02, 3); idle(20);       // fourth edge: accepted
    check("R3 last window edge", rd_data[3:0], 2);
    tag = "R3"; unlock_sel(8'h05, 4); idle(20);       // fifth edge: rejected
    check("R3 window expired", rd_data[3:0], 2);
    tag = "R5";
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h80;
    @(negedge clk); wr_data = 8'h80;
    @(negedge clk); wr_data = 8'h80;
    @(negedge clk); wr_en = 1'b0;
    idle(2);
    check("R5 no extension", rd_data[7], 0);
    tag = "R2"; wr(8'h81); check("R2 bad unlock", rd_data[7], 0);
    wr(8'hC0); check("R2 bad unlock C0", rd_data[7], 0);
    tag = "R6"; wr(8'h01); idle(2); check("R6 locked write", rd_data[3:0], 2);
    tag = "R7"; unlock_sel(8'h0A, 1);
    check("R7 reserved keeps sel", rd_data[3:0], 2);
    check("R7 reserved clears flag", rd_data[7], 0);
    tag = "R4"; unlock_sel(8'h08, 0);
    check("R4 flag cleared", rd_data[7], 0);
    idle(600);
    tag = "R9"; unlock_sel(8'h00, 2); idle(300);
    unlock_sel(8'h01, 0); idle(10);

    tag = "RND";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      @(negedge clk);
      if (r < 3) begin wr_en = 1'b1; wr_data = 8'h80; end
      else if (r < 5) begin wr_en = 1'b1; wr_data = 8'($urandom_range(0, 15)); end
      else if (r < 6) begin wr_en = 1'b1; wr_data = 8'($urandom); end
      else wr_en = 1'b0;
    end
    @(negedge clk); wr_en = 1'b0;
    idle(300);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule